// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of a high-precision event timer. A shared 64-bit main counter, which runs freely outside the channel, is presented on `cnt_i`. The channel holds three pieces of state. The first is a configuration word. The second is a target value that is compared against the counter. The third is a reload period. Through these the channel raises an interrupt request and a status bit toward the global timer block. A parent address decoder reaches the configuration word and the target through separate write strobes. Both writes share one byte-lane mask and one write-data bus.

The channel can fire once (one-shot) or re-arm itself after every match (periodic). It can compare all 64 bits or only the low 32 bits. It signals either as a sticky level or as a one-cycle edge pulse. The match test is wrap-safe: the target counts as reached once the signed difference `counter - target` is zero or positive. In 32-bit one-shot operation, the channel also fires when the low half of the counter rolls over.

Top module: `evt_cmp_chan`

## Requirements
- R1: After a synchronous reset, the configuration readback holds only the capability bits (bit 4 periodic capable, bit 5 64-bit capable, bit 15 message-delivery capable, bits 63:32 route capability), the target reads all ones, and `sts_o` and `irq_o` are 0.
- R2: A configuration write changes only the writable bits, and only in byte lanes whose `be_i` bit is set. The writable bits are 1 (level), 2 (enable), 3 (periodic, only when periodic capable), 6 (value-set), 8 (force 32-bit), 13:9 (route index) and 14 (message-delivery enable). Capability bits ignore writes, and every other bit reads 0.
- R3: An armed one-shot target fires exactly once, in the first cycle whose counter value satisfies signed(`cnt_i - target`) >= 0. A target already in the past fires at once, and the test holds across the 64-bit counter wrap. A target write arms the channel.
- R4: In edge mode (bit 1 = 0), a firing sets `sts_o` for exactly the one cycle after the firing clock edge, and `irq_o` follows it while the channel is enabled.
- R5: With enable (bit 2) at 0, a firing still updates `sts_o` but `irq_o` stays 0.
- R6: In level mode (bit 1 = 1), `sts_o` stays set after a firing until `sts_clr_i` is pulsed. Clearing the enable bit does not clear it, and `irq_o` equals `sts_o` while enabled.
- R7: A configuration write that changes bit 1 from 1 to 0 clears `sts_o` and `irq_o` on that edge.
- R8: In periodic mode, each firing adds the period to the target, so firings repeat every period cycles. A target write made while bit 6 is 1 also loads the period, and bit 6 then reads 0.
- R9: With bit 8 set, only the low 32 bits of counter and target are compared, and the target's upper half reads as zero.
- R10: In 32-bit one-shot mode, the channel also fires in the cycle in which the low 32 counter bits step from 0xFFFF_FFFF to 0. It does not do so in periodic mode or in 64-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Shared main counter value |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cmp_we_i | input | 1 | Target/period write strobe |
| be_i | input | 8 | Byte-lane enables for either write |
| wdata_i | input | 64 | Write data |
| sts_clr_i | input | 1 | Clear request for the level-mode status bit |
| cfg_rd_o | output | 64 | Configuration word readback |
| cmp_rd_o | output | 64 | Target readback |
| sts_o | output | 1 | Channel status toward the global block |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sets targets slightly in the past and across the 64-bit rollover. A design using an unsigned comparison would fire many cycles early, or never fire at all. It drives the low counter half through its rollover in three configurations: one-shot 32-bit, periodic 32-bit and 64-bit. A design that mis-qualified the rollover event would miss the extra firing or add spurious ones. It switches a pending level channel to edge mode, and disables a pending level channel. A design that tied status to the enable or to the trigger type in the wrong way would drop or keep the bit wrongly. Random byte-lane configuration writes catch capability bits that can be overwritten and lanes merged with the wrong mask.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CNT_W   = 64;
    localparam int unsigned HALF_W  = 32;
    localparam int unsigned LANES   = CNT_W / 8;
    localparam int unsigned ROUTE_W = 5;

    // base writable configuration bits (periodic select added per capability)
    localparam logic [CNT_W-1:0] WR_BASE = 64'h0000_0000_0000_7F46;
    localparam logic [CNT_W-1:0] WR_PER  = 64'h0000_0000_0000_0008;

    typedef struct packed {
        logic               fsb_en;
        logic [ROUTE_W-1:0] route;
        logic               m32;
        logic               vset;
        logic               per;
        logic               en;
        logic               lvl;
    } chan_cfg_t;

    function automatic logic [CNT_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [CNT_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] tgt,
                                     input logic             m32);
        logic [CNT_W-1:0]  d64;
        logic [HALF_W-1:0] d32;
        d64 = cnt - tgt;
        d32 = cnt[HALF_W-1:0] - tgt[HALF_W-1:0];
        return m32 ? ~d32[HALF_W-1] : ~d64[CNT_W-1];
    endfunction

    function automatic logic [CNT_W-1:0] cfg_to_word(input chan_cfg_t c,
                                                      input logic [CNT_W-1:0] caps);
        logic [CNT_W-1:0] w;
        w      = caps;
        w[1]   = c.lvl;
        w[2]   = c.en;
        w[3]   = c.per;
        w[6]   = c.vset;
        w[8]   = c.m32;
        w[13:9] = c.route;
        w[14]  = c.fsb_en;
        return w;
    endfunction

    function automatic chan_cfg_t word_to_cfg(input logic [CNT_W-1:0] w);
        chan_cfg_t c;
        c.lvl    = w[1];
        c.en     = w[2];
        c.per    = w[3];
        c.vset   = w[6];
        c.m32    = w[8];
        c.route  = w[13:9];
        c.fsb_en = w[14];
        return c;
    endfunction

endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
    import tmr_pkg::*;
#(
    parameter bit          PER_CAP   = 1'b1,
    parameter bit          WIDE_CAP  = 1'b1,
    parameter bit          FSB_CAP   = 1'b0,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic             cmp_we_i,
    input  logic [LANES-1:0] be_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rd_o,
    output logic             lvl_o,
    output logic             en_o,
    output logic             per_o,
    output logic             vset_o,
    output logic             m32_o,
    output logic             lvl_fall_o
);
    localparam logic [CNT_W-1:0] CAPS =
        {ROUTE_CAP, 16'h0000, FSB_CAP, 9'h000, WIDE_CAP, PER_CAP, 4'h0};

    logic [CNT_W-1:0] wmask;
    generate
        if (PER_CAP) begin : g_per
            assign wmask = WR_BASE | WR_PER;
        end else begin : g_noper
            assign wmask = WR_BASE;
        end
    endgenerate

    chan_cfg_t        cfg_q, cfg_new;
    logic [CNT_W-1:0] m, merged;

    always_comb begin
        rd_o    = cfg_to_word(cfg_q, CAPS);
        m       = lane_mask(be_i) & wmask;
        merged  = (rd_o & ~m) | (wdata_i & m);
        cfg_new = word_to_cfg(merged);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= cfg_new;
        end else if (cmp_we_i) begin
            cfg_q.vset <= 1'b0;
        end
    end

    assign lvl_o      = cfg_q.lvl;
    assign en_o       = cfg_q.en;
    assign per_o      = cfg_q.per;
    assign vset_o     = cfg_q.vset;
    assign m32_o      = cfg_q.m32;
    assign lvl_fall_o = we_i & cfg_q.lvl & ~cfg_new.lvl;

    // R8
    vset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_we_i && !we_i) |=> !vset_o);

endmodule

// File: rtl/evt_cmp_unit.sv
module evt_cmp_unit
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             per_i,
    input  logic             vset_i,
    input  logic             mode32_i,
    input  logic             we_i,
    input  logic [LANES-1:0] be_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] tgt_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] tgt_q, per_q, wm, tgt_wr, per_wr, tgt_step;
    logic             armed_q, prev_b31_q, match, wrap;

    always_comb begin
        wm = lane_mask(be_i);
        if (mode32_i) wm[CNT_W-1:HALF_W] = '0;
        tgt_wr = (tgt_q & ~wm) | (wdata_i & wm);
        per_wr = (per_q & ~wm) | (wdata_i & wm);
        if (mode32_i)
            tgt_step = {tgt_q[CNT_W-1:HALF_W], tgt_q[HALF_W-1:0] + per_q[HALF_W-1:0]};
        else
            tgt_step = tgt_q + per_q;
        match = armed_q & reached(cnt_i, tgt_q, mode32_i);
        wrap  = mode32_i & ~per_i & prev_b31_q & ~cnt_i[HALF_W-1];
        hit_o = match | wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q      <= '1;
            per_q      <= '0;
            armed_q    <= 1'b0;
            prev_b31_q <= 1'b0;
        end else begin
            prev_b31_q <= cnt_i[HALF_W-1];
            if (we_i) begin
                tgt_q   <= tgt_wr;
                armed_q <= 1'b1;
                if (vset_i) per_q <= per_wr;
            end else if (match) begin
                if (per_i) tgt_q   <= tgt_step;
                else       armed_q <= 1'b0;
            end
        end
    end

    assign tgt_o = tgt_q;

    // R3
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (match && !per_i && !we_i) |=> !armed_q);

    // R8
    period_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (match && per_i && !we_i && !mode32_i) |=> ((tgt_q - $past(tgt_q)) == $past(per_q)));

    // R9
    low_half_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode32_i && armed_q && cnt_i[HALF_W-1:0] == tgt_q[HALF_W-1:0]) |-> hit_o);

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic en_i,
    input  logic hit_i,
    input  logic clr_i,
    input  logic lvl_fall_i,
    output logic sts_o,
    output logic irq_o
);
    logic sts_q;

    always_ff @(posedge clk) begin
        if (rst)             sts_q <= 1'b0;
        else if (lvl_fall_i) sts_q <= 1'b0;
        else if (lvl_i)      sts_q <= (sts_q & ~clr_i) | hit_i;
        else                 sts_q <= hit_i;
    end

    assign sts_o = sts_q;
    assign irq_o = sts_q & en_i;

    // R4
    edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!lvl_i && !hit_i) |=> !sts_o);

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_i && sts_o && !clr_i && !lvl_fall_i) |=> sts_o);

    // R7
    type_clear_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_fall_i |=> !sts_o);

endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan
    import tmr_pkg::*;
#(
    parameter bit          PER_CAP   = 1'b1,
    parameter bit          WIDE_CAP  = 1'b1,
    parameter bit          FSB_CAP   = 1'b0,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] cnt_i,
    input  logic        cfg_we_i,
    input  logic        cmp_we_i,
    input  logic [7:0]  be_i,
    input  logic [63:0] wdata_i,
    input  logic        sts_clr_i,
    output logic [63:0] cfg_rd_o,
    output logic [63:0] cmp_rd_o,
    output logic        sts_o,
    output logic        irq_o
);
    logic             lvl, en, per, vset, m32, lvl_fall, mode32, hit;
    logic [CNT_W-1:0] tgt;

    evt_cfg_reg #(
        .PER_CAP(PER_CAP), .WIDE_CAP(WIDE_CAP),
        .FSB_CAP(FSB_CAP), .ROUTE_CAP(ROUTE_CAP)
    ) u_cfg (
        .clk(clk), .rst(rst), .we_i(cfg_we_i), .cmp_we_i(cmp_we_i),
        .be_i(be_i), .wdata_i(wdata_i), .rd_o(cfg_rd_o),
        .lvl_o(lvl), .en_o(en), .per_o(per), .vset_o(vset),
        .m32_o(m32), .lvl_fall_o(lvl_fall)
    );

    assign mode32 = m32 | ~WIDE_CAP;

    evt_cmp_unit u_cmp (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .per_i(per), .vset_i(vset),
        .mode32_i(mode32), .we_i(cmp_we_i), .be_i(be_i), .wdata_i(wdata_i),
        .tgt_o(tgt), .hit_o(hit)
    );

    evt_irq_unit u_irq (
        .clk(clk), .rst(rst), .lvl_i(lvl), .en_i(en), .hit_i(hit),
        .clr_i(sts_clr_i), .lvl_fall_i(lvl_fall), .sts_o(sts_o), .irq_o(irq_o)
    );

    assign cmp_rd_o = mode32 ? {{HALF_W{1'b0}}, tgt[HALF_W-1:0]} : tgt;

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd_o[2] |-> !irq_o);

    // R10
    low_wrap_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_o[8] && !cfg_rd_o[3] && $past(cnt_i[31]) && !cnt_i[31] && !lvl_fall)
        |=> sts_o);

endmodule

// File: tb/sim_evt_cmp_chan.sv
module sim_evt_cmp_chan;
    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic [63:0] cnt_i = '0;
    logic        cfg_we = 1'b0, cmp_we = 1'b0, sts_clr = 1'b0;
    logic [7:0]  be = '0;
    logic [63:0] wdata = '0;
    logic [63:0] cfg_rd, cmp_rd;
    logic        sts, irq;

    int          nvec = 0, nerr = 0;
    bit          done = 1'b0;
    logic [63:0] cnt = '0;

    localparam logic [63:0] CAPS = 64'h00F0_0000_0000_0030;
    localparam logic [63:0] WM   = 64'h0000_0000_0000_7F4E;

    evt_cmp_chan u0 (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .cfg_we_i(cfg_we), .cmp_we_i(cmp_we),
        .be_i(be), .wdata_i(wdata), .sts_clr_i(sts_clr),
        .cfg_rd_o(cfg_rd), .cmp_rd_o(cmp_rd), .sts_o(sts), .irq_o(irq)
    );

    function automatic logic [63:0] lanes(input logic [7:0] b);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{b[i]}};
        return m;
    endfunction

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input bit es, input bit ei);
        chk({req, " sts"}, {63'b0, sts}, {63'b0, es});
        chk({req, " irq"}, {63'b0, irq}, {63'b0, ei});
    endtask

    task automatic do_reset;
        rst = 1'b1; cnt = '0; cnt_i = '0;
        step; step;
        rst = 1'b0;
    endtask

    task automatic wr_cfg(input logic [63:0] v, input logic [7:0] b);
        cfg_we = 1'b1; be = b; wdata = v; cnt_i = cnt;
        step;
        cfg_we = 1'b0; be = '0;
    endtask

    task automatic wr_cmp(input logic [63:0] v);
        cmp_we = 1'b1; be = 8'hFF; wdata = v; cnt_i = cnt;
        step;
        cmp_we = 1'b0; be = '0;
    endtask

    task automatic adv;
        cnt = cnt + 1; cnt_i = cnt;
        step;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        #(64'd20 * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            summary;
            $finish;
        end
    end

    initial begin
        logic [63:0] model, w;
        logic [7:0]  b;
        int          d, p;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset;

        // R1 reset state
        chk("R1 cfg", cfg_rd, CAPS);
        chk("R1 cmp", cmp_rd, 64'hFFFF_FFFF_FFFF_FFFF);
        chk_out("R1", 1'b0, 1'b0);

        // R2 directed and random byte-lane writes
        wr_cfg('1, 8'hFF);
        chk("R2 all ones", cfg_rd, CAPS | WM);
        wr_cfg('0, 8'h01);
        chk("R2 lane0 only", cfg_rd, CAPS | 64'h7F00);
        model = 64'h7F00;
        for (int i = 0; i < 10; i++) begin
            w = {$urandom, $urandom};
            b = 8'($urandom);
            model = (model & ~(lanes(b) & WM)) | (w & lanes(b) & WM);
            wr_cfg(w, b);
            chk("R2 random", cfg_rd, CAPS | model);
        end
        wr_cfg('0, 8'hFF);
        chk("R2 cleared", cfg_rd, CAPS);

        // R3 R4 one-shot edge with random distances
        wr_cfg(64'h4, 8'hFF);
        cnt = 64'h0000_0003_1234_5600;
        for (int i = 0; i < 6; i++) begin
            d = 1 + int'($urandom % 12);
            wr_cmp(cnt + 64'(d));
            for (int k = 1; k <= d + 3; k++) begin
                adv;
                chk_out("R3 R4 one-shot", k == d, k == d);
            end
        end

        // R3 target already in the past
        wr_cmp(cnt - 64'd5);
        adv;
        chk_out("R3 late target", 1'b1, 1'b1);
        adv;
        chk_out("R3 late target once", 1'b0, 1'b0);

        // R3 across 64-bit counter wrap
        cnt = 64'hFFFF_FFFF_FFFF_FFFD;
        wr_cmp(64'd1);
        for (int k = 1; k <= 5; k++) begin
            adv;
            chk_out("R3 64-bit wrap", k == 4, k == 4);
        end

        // R5 disabled channel
        wr_cfg(64'h0, 8'hFF);
        wr_cmp(cnt + 64'd2);
        adv;
        chk_out("R5 before", 1'b0, 1'b0);
        adv;
        chk_out("R5 gated", 1'b1, 1'b0);

        // R6 level mode
        wr_cfg(64'h6, 8'hFF);
        wr_cmp(cnt + 64'd2);
        adv; adv;
        chk_out("R6 fire", 1'b1, 1'b1);
        adv; adv;
        chk_out("R6 sticky", 1'b1, 1'b1);
        wr_cfg(64'h2, 8'hFF);
        chk_out("R6 disarm keeps", 1'b1, 1'b0);
        sts_clr = 1'b1; step; sts_clr = 1'b0;
        chk_out("R6 cleared", 1'b0, 1'b0);

        // R7 level to edge clears pending status
        wr_cfg(64'h6, 8'hFF);
        wr_cmp(cnt + 64'd1);
        adv;
        chk_out("R7 pending", 1'b1, 1'b1);
        wr_cfg(64'h4, 8'hFF);
        chk_out("R7 switched", 1'b0, 1'b0);

        // R8 periodic with value-set
        do_reset;
        wr_cfg(64'h4C, 8'hFF);
        chk("R8 vset set", cfg_rd, CAPS | 64'h4C);
        p = 2 + int'($urandom % 8);
        wr_cmp(64'(p));
        chk("R8 vset self-clears", cfg_rd, CAPS | 64'h0C);
        d = 1 + int'($urandom % 5);
        wr_cmp(cnt + 64'(d));
        for (int k = 1; k <= d + 3 * p; k++) begin
            adv;
            chk_out("R8 periodic", (k >= d) && ((k - d) % p == 0), (k >= d) && ((k - d) % p == 0));
        end

        // R9 32-bit compare, upper half reads zero
        do_reset;
        wr_cfg(64'h104, 8'hFF);
        cnt = 64'h0000_0005_0000_0100;
        wr_cmp(64'hABCD_0000_0000_0105);
        chk("R9 upper zero", cmp_rd, 64'h0000_0000_0000_0105);
        for (int k = 1; k <= 7; k++) begin
            adv;
            chk_out("R9 low compare", k == 5, k == 5);
        end

        // R10 one-shot 32-bit wrap fires
        do_reset;
        wr_cfg(64'h104, 8'hFF);
        cnt = 64'h0000_0007_FFFF_FFFC;
        wr_cmp(64'h7000_0000);
        for (int k = 1; k <= 6; k++) begin
            adv;
            chk_out("R10 wrap one-shot", k == 4, k == 4);
        end

        // R10 periodic 32-bit: no wrap firing
        do_reset;
        wr_cfg(64'h10C, 8'hFF);
        cnt = 64'h0000_0007_FFFF_FFFC;
        wr_cmp(64'h7000_0000);
        for (int k = 1; k <= 6; k++) begin
            adv;
            chk_out("R10 periodic no wrap", 1'b0, 1'b0);
        end

        // R10 64-bit one-shot: low-half wrap is not an event
        do_reset;
        wr_cfg(64'h4, 8'hFF);
        cnt = 64'h0000_0007_FFFF_FFFC;
        wr_cmp(64'h0000_0009_0000_0000);
        for (int k = 1; k <= 6; k++) begin
            adv;
            chk_out("R10 64-bit no wrap", 1'b0, 1'b0);
        end

        done = 1'b1;
        summary;
        $finish;
    end
endmodule